// File: doc/BRIEF.md
# Return Address Stack with Shift-Sequence Pointer

This block is an eight-deep store of 14-bit return addresses for a small processor core. A call pushes the address to come back to, and a return pops it. The pointer that selects the active slot is not a binary counter. It is a 3-bit shift register that walks the cyclic bit string 00010111, one window of three bits at a time. A forward shift moves it for a push, and the matching reverse shift moves it back for a pop.

The active slot is always visible on `top_o`, without a clock cycle of delay. A return therefore reads `top_o` in the same cycle that it asserts `pop_i`. The stack has no full or empty indication. A ninth push overwrites the oldest address without any warning, and a pop past the bottom wraps in the same way.

Top module: `dbj_ret_stack`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `ptr_o` is 3'b000 and every slot holds zero. Popping straight after reset therefore returns zero from every slot.
- R2: Each push moves the pointer forward with `next = {ptr[1:0], b}`. From reset the successive values are 000, 001, 010, 101, 011, 111, 110, 100, and then 000 again. These are the 3-bit windows of the cyclic string 00010111.
- R3: A push first moves the pointer and then writes `data_i` into the slot at the new pointer. In the cycle after the push, `top_o` equals that `data_i`.
- R4: In the cycle that `pop_i` is asserted, `top_o` shows the slot at the current pointer. On the clock edge the pointer steps back with `prev = {b, ptr[2:1]}`, which is the reverse of the R2 order. A pop does not change the stored contents.
- R5: A push followed directly by a pop leaves `ptr_o` at its value before the push.
- R6: Eight pushes in a row return `ptr_o` to the value it had before them.
- R7: A ninth push without any pops overwrites the slot that holds the oldest entry, and no error is raised. Eight pops that follow return the last eight pushes in LIFO order, and the oldest entry is lost.
- R8: In a cycle with neither push nor pop, `ptr_o` and `top_o` keep their values.
- R9: When `push_i` and `pop_i` are both asserted, the push wins and the pop is ignored.
- R10: A pop at pointer 000 wraps to 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push `data_i` (call) |
| pop_i | input | 1 | Pop the top entry (return) |
| data_i | input | 14 | Address to push |
| top_o | output | 14 | Entry at the current pointer |
| ptr_o | output | 3 | Current stack pointer |

## Verification
The assertions assume that `push_i`, `pop_i` and `data_i` are known values that stay steady around the rising edge. Their one-cycle and two-cycle relations rely on this. For the same reason the bench changes its inputs only on falling edges.

Simultaneous push and pop is legal for the block. The properties are written so that they still hold in that case. The pop checks apply only to cycles that are pop-only, and the bench drives the simultaneous case on purpose.

The stimulus covers a full forward lap, a full backward lap, overflow past eight pushes, and underflow from the reset pointer.

// File: rtl/dbj_pkg.sv
package dbj_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/dbj_step.sv
// Forward and backward neighbours of a pointer on a cyclic shift sequence
module dbj_step #(
  parameter int                        PTR_W = 3,
  parameter logic [(1<<PTR_W)-1:0]     SEQ   = 8'b00010111
) (
  input  logic [PTR_W-1:0] ptr_i,
  output logic [PTR_W-1:0] fwd_o,
  output logic [PTR_W-1:0] bwd_o
);
  localparam int DEPTH = 1 << PTR_W;

  // bit k of the cyclic string, first character first
  function automatic logic seq_at(int k);
    logic [DEPTH-1:0] s;
    s = SEQ;
    return s[DEPTH-1-(k % DEPTH)];
  endfunction

  function automatic logic [PTR_W-1:0] win(int i);
    logic [PTR_W-1:0] w;
    for (int j = 0; j < PTR_W; j++) w[PTR_W-1-j] = seq_at(i + j);
    return w;
  endfunction

  logic [DEPTH-1:0] fwd_hit, bwd_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_win
    localparam logic [PTR_W-1:0] WIN_G = win(g);
    localparam logic             FB_G  = seq_at(g + PTR_W);
    localparam logic             BB_G  = seq_at(g + DEPTH - 1);
    assign fwd_hit[g] = (ptr_i == WIN_G) & FB_G;
    assign bwd_hit[g] = (ptr_i == WIN_G) & BB_G;
  end

  assign fwd_o = {ptr_i[PTR_W-2:0], |fwd_hit};
  assign bwd_o = {|bwd_hit, ptr_i[PTR_W-1:1]};
endmodule

// File: rtl/dbj_ptr_reg.sv
module dbj_ptr_reg
  import dbj_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  input  logic [PTR_W-1:0] fwd_i,
  input  logic [PTR_W-1:0] bwd_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_d, ptr_q;

  always_comb begin
    unique case (op_i)
      OP_PUSH: ptr_d = fwd_i;
      OP_POP:  ptr_d = bwd_i;
      default: ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dbj_entry_file.sv
module dbj_entry_file #(
  parameter int ADDR_W = 14,
  parameter int PTR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [ADDR_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << PTR_W;

  logic [ADDR_W-1:0] rd_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ADDR_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       ent_q <= '0;
      else if (we_i && (waddr_i == PTR_W'(g)))           ent_q <= wdata_i;
    end
    assign rd_arr[g] = ent_q;
  end

  assign rdata_o = rd_arr[raddr_i];
endmodule

// File: rtl/dbj_ret_stack.sv
module dbj_ret_stack
  import dbj_pkg::*;
#(
  parameter int                    ADDR_W = 14,
  parameter int                    PTR_W  = 3,
  parameter logic [(1<<PTR_W)-1:0] SEQ    = 8'b00010111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] top_o,
  output logic [PTR_W-1:0]  ptr_o
);
  stk_op_e          op;
  logic [PTR_W-1:0] ptr_q, ptr_fwd, ptr_bwd;

  // push wins over pop
  always_comb begin
    if (push_i)     op = OP_PUSH;
    else if (pop_i) op = OP_POP;
    else            op = OP_IDLE;
  end

  dbj_step #(.PTR_W(PTR_W), .SEQ(SEQ)) u_step (
    .ptr_i (ptr_q),
    .fwd_o (ptr_fwd),
    .bwd_o (ptr_bwd)
  );

  dbj_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .fwd_i  (ptr_fwd),
    .bwd_i  (ptr_bwd),
    .ptr_o  (ptr_q)
  );

  // push writes at the advanced pointer
  dbj_entry_file #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ents (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (op == OP_PUSH),
    .waddr_i (ptr_fwd),
    .wdata_i (data_i),
    .raddr_i (ptr_q),
    .rdata_o (top_o)
  );

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dbj_ret_stack_chk.sv
module dbj_ret_stack_chk #(
  parameter int ADDR_W = 14,
  parameter int PTR_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] data_i,
  input logic [ADDR_W-1:0] top_o,
  input logic [PTR_W-1:0]  ptr_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_STATE: assert (ptr_o == '0 && top_o == '0); // R1
  end

  AST_PUSH_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> ptr_o[PTR_W-1:1] == $past(ptr_o[PTR_W-2:0])); // R2

  AST_STEP_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || pop_i) |=> ptr_o != $past(ptr_o)); // R2

  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(data_i)); // R3

  AST_POP_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> ptr_o[PTR_W-2:0] == $past(ptr_o[PTR_W-1:1])); // R4

  AST_PUSH_POP_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i ##1 (pop_i && !push_i) |=> ptr_o == $past(ptr_o, 2)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(ptr_o) && $stable(top_o)); // R8
endmodule

bind dbj_ret_stack dbj_ret_stack_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/dbj_ret_stack_tb.sv
`timescale 1ns/1ps
module dbj_ret_stack_tb;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0, pop = 1'b0;
  logic [AW-1:0] din = '0;
  logic [AW-1:0] top;
  logic [2:0]    ptr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  dbj_ret_stack u_dut (
    .clk_i (clk), .rst_ni (rst_n), .push_i (push), .pop_i (pop),
    .data_i (din), .top_o (top), .ptr_o (ptr)
  );

  // pointer at each position of the sequence (R2)
  localparam logic [2:0] ORDER [8] = '{3'd0, 3'd1, 3'd2, 3'd5, 3'd3, 3'd7, 3'd6, 3'd4};

  int            m_idx;
  logic [AW-1:0] m_mem [8];

  logic [16:0] q_exp [$];
  string       q_tag [$];

  task automatic chk(input logic [16:0] act, input logic [16:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [16:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk({ptr, top}, e, t);
    end
  end

  task automatic model_reset();
    m_idx = 0;
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
  endtask

  task automatic step(input logic p, input logic o, input logic [AW-1:0] d, input string tag);
    @(negedge clk);
    if (o && !p) chk({3'b0, top}, {3'b0, m_mem[m_idx]}, {tag, " pop-return"}); // R4
    push = p; pop = o; din = d;
    if (p) begin
      m_idx = (m_idx + 1) % 8;
      m_mem[m_idx] = d;
    end else if (o) begin
      m_idx = (m_idx + 7) % 8;
    end
    q_exp.push_back({ORDER[m_idx], m_mem[m_idx]});
    q_tag.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    push = 0; pop = 0; rst_n = 0;
    model_reset();
    @(negedge clk);
    chk({ptr, top}, 17'd0, "R1 in reset");
    rst_n = 1;
  endtask

  initial begin
    model_reset();
    do_reset();
    @(negedge clk);
    chk({ptr, top}, 17'd0, "R1 after reset");

    // R10 / R1: underflow from reset, cleared slots
    step(0, 1, '0, "R10 underflow wrap");
    step(0, 1, '0, "R1 cleared slot");
    do_reset();

    // full forward lap, R2 R3 R6
    for (int i = 0; i < 8; i++) step(1, 0, AW'(14'h100 + i), "R2 R3 push");
    step(0, 0, '0, "R6 lap return");
    for (int i = 0; i < 3; i++) step(0, 0, 14'h3fff, "R8 idle");
    // full backward lap, R4
    for (int i = 0; i < 8; i++) step(0, 1, '0, "R4 pop");

    // push then pop, R5
    for (int i = 0; i < 4; i++) begin
      step(1, 0, AW'(14'h2a0 + i), "R5 push");
      step(0, 1, '0, "R5 pop");
    end

    // overflow, R7
    do_reset();
    for (int i = 0; i < 9; i++) step(1, 0, AW'(14'h0a0 + i), "R7 push");
    for (int i = 0; i < 8; i++) step(0, 1, '0, "R7 pop");
    step(0, 0, '0, "R7 oldest lost");
    chk({3'b0, m_mem[m_idx]}, {3'b0, 14'h0a8}, "R7 model");

    // simultaneous, R9
    step(1, 1, 14'h155, "R9 push wins");
    step(1, 1, 14'h0aa, "R9 push wins");
    step(0, 1, '0, "R9 pop after");

    step(0, 0, '0, "R8 drain");
    step(0, 0, '0, "R8 drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule